// File: doc/BRIEF.md
# Shift-Register Clock Divider Chain

This block is the digital control portion of a clock synthesizer. It holds two programmable dividers and a two-stage post-divider, all running from one supplied fast clock. The reference divider (6 bits) and the feedback divider (8 bits) are each a shift register with linear feedback, not a binary counter. The register steps once per clock. When it reaches the terminal state it loads the divider's reload input instead of stepping, and its divided output flips. The divide ratio is set by where the reload value sits in the register's state sequence. A value that lies N−1 steps before the terminal state gives one terminal event every N clocks.

The post-divider is set through one packed configuration word. It holds two 3-bit fields, and each field encodes eight minus that stage's divisor. The two stages are cascaded down counters, so the output enable comes once every product of the two divisors. All outputs are one-clock enables or flip levels in the fast-clock domain. The analog phase comparison and the oscillator that use them lie outside this block.

A small sequencer runs the block. After reset it is in ST_LOAD, which lasts one cycle. There it takes the reload inputs and the post-divider configuration, and every enable is held low. Its only transition, LOAD_TO_RUN, is unconditional and leads to ST_RUN. That state holds through the transition RUN_STAY until the next reset, and every divider advances there.

Top module: `clksyn_div_chain`

## Requirements
- R1: While reset is asserted, and in cycle 0 (the cycle before the first rising edge after reset release), ref_tick_o, fb_tick_o and post_en_o are low and ref_div_o and fb_div_o are 0. Cycle k is the cycle that follows the k-th rising edge after release.
- R2: The reference register steps as next = {s[4:0], s[5]^s[4]^(s[4:0]==0)}, and the terminal state is 1. If ref_reload_i holds the state N−1 steps before 1, ref_tick_o is high in cycles N, 2N, 3N and so on. This holds for every N from 1 to 64.
- R3: The feedback register steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]^(s[6:0]==0)}, and the terminal state is 1. If fb_reload_i holds the state N−1 steps before 1, fb_tick_o is high in cycles N, 2N and so on. This holds for every N from 2 to 256.
- R4: ref_div_o and fb_div_o change only on the rising edge that ends a cycle in which their tick is high, and they invert on that edge.
- R5: post_cfg_i[5:3] holds 8 − d1 and post_cfg_i[2:0] holds 8 − d2, where each divisor is from 1 to 8. post_en_o is high in cycles d1·d2, 2·d1·d2 and so on.
- R6: A new reload value is taken only at the divider's terminal event. The interval already running finishes at its old length, and each interval after it has the new length.
- R7: A post-divider configuration present during a cycle in which post_en_o is high sets the length of the whole next post-divider period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock that drives all dividers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_reload_i | input | 6 | Reload state for the reference divider |
| fb_reload_i | input | 8 | Reload state for the feedback divider |
| post_cfg_i | input | 6 | Packed post-divider fields, {8−d1, 8−d2} |
| ref_tick_o | output | 1 | One-cycle enable at each reference terminal event |
| ref_div_o | output | 1 | Divided reference level, inverts after each terminal event |
| fb_tick_o | output | 1 | One-cycle enable at each feedback terminal event |
| fb_div_o | output | 1 | Divided feedback level, inverts after each terminal event |
| post_en_o | output | 1 | One-cycle enable at the post-divided rate |

## Verification
The hardest cases to reach are a reload change that arrives in the middle of an interval, and a post-divider change that arrives exactly in a cycle where the two stages reload together. The bench counts cycles from reset release. It applies the new values just after a chosen rising edge, timed to fall before a known terminal event, or in the cycle where post_en_o is expected. The expected schedule keeps the old length up to that event and uses the new length after it. The extreme ratios are also run in full: divisor 1, divisor 64, divisor 256, and a post product of 64. Their reload values come from stepping the state sequence backwards from the terminal state.

// File: rtl/clksyn_pkg.sv
`timescale 1ns/1ps
package clksyn_pkg;

    // Sequencer states of the divider chain
    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/clksyn_lfsr_div.sv
`timescale 1ns/1ps
// Shift-register divider: steps each cycle, reloads at the terminal state.
// The zero-insertion term extends the sequence to all 2**W states.
module clksyn_lfsr_div #(
    parameter int             W    = 6,
    parameter logic [W-1:0]   TAPS = 6'h30,
    parameter logic [W-1:0]   TERM = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] reload_i,
    output logic         tick_o,
    output logic         div_o,
    output logic [W-1:0] state_o
);

    logic [W-1:0] sr_q;
    logic [W-1:0] sr_nxt;
    logic         fb_bit;
    logic         div_q;

    always_comb begin
        fb_bit = (^(sr_q & TAPS)) ^ (sr_q[W-2:0] == '0);
        sr_nxt = {sr_q[W-2:0], fb_bit};
    end

    assign tick_o  = run_i && (sr_q == TERM);
    assign div_o   = div_q;
    assign state_o = sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q  <= '0;
            div_q <= 1'b0;
        end else if (load_i) begin
            sr_q  <= reload_i;
            div_q <= 1'b0;
        end else if (run_i) begin
            if (tick_o) begin
                sr_q  <= reload_i;
                div_q <= ~div_q;
            end else begin
                sr_q  <= sr_nxt;
            end
        end
    end

endmodule

// File: rtl/clksyn_post_stage.sv
`timescale 1ns/1ps
// One post-divider stage: a down counter advanced by step_i.
module clksyn_post_stage #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [CW-1:0] div_i,
    output logic          tick_o
);

    logic [CW-1:0] cnt_q;

    assign tick_o = step_i && (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= div_i - CW'(1);
        end else if (step_i) begin
            if (cnt_q == '0) begin
                cnt_q <= div_i - CW'(1);
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

endmodule

// File: rtl/clksyn_div_chain.sv
`timescale 1ns/1ps
module clksyn_div_chain
    import clksyn_pkg::*;
#(
    parameter int                REF_W    = 6,
    parameter logic [REF_W-1:0]  REF_TAPS = 6'h30,
    parameter int                FB_W     = 8,
    parameter logic [FB_W-1:0]   FB_TAPS  = 8'hB8,
    parameter int                PD_W     = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [REF_W-1:0]    ref_reload_i,
    input  logic [FB_W-1:0]     fb_reload_i,
    input  logic [2*PD_W-1:0]   post_cfg_i,
    output logic                ref_tick_o,
    output logic                ref_div_o,
    output logic                fb_tick_o,
    output logic                fb_div_o,
    output logic                post_en_o
);

    localparam int               PD_CW   = PD_W + 1;
    localparam int               N_STG   = 2;
    localparam logic [PD_CW-1:0] PD_SPAN = PD_CW'(2 ** PD_W);

    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       in_load;
    logic       in_run;

    logic [REF_W-1:0] ref_state;
    logic [FB_W-1:0]  fb_state;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions: LOAD_TO_RUN, RUN_STAY
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_LOAD: state_nxt = ST_RUN;
            ST_RUN:  state_nxt = ST_RUN;
            default: state_nxt = ST_LOAD;
        endcase
    end

    // State outputs
    always_comb begin
        in_load = 1'b0;
        in_run  = 1'b0;
        unique case (state_q)
            ST_LOAD: in_load = 1'b1;
            ST_RUN:  in_run  = 1'b1;
            default: in_load = 1'b0;
        endcase
    end

    clksyn_lfsr_div #(
        .W    (REF_W),
        .TAPS (REF_TAPS),
        .TERM (REF_W'(1))
    ) i_ref_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (in_load),
        .run_i    (in_run),
        .reload_i (ref_reload_i),
        .tick_o   (ref_tick_o),
        .div_o    (ref_div_o),
        .state_o  (ref_state)
    );

    clksyn_lfsr_div #(
        .W    (FB_W),
        .TAPS (FB_TAPS),
        .TERM (FB_W'(1))
    ) i_fb_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (in_load),
        .run_i    (in_run),
        .reload_i (fb_reload_i),
        .tick_o   (fb_tick_o),
        .div_o    (fb_div_o),
        .state_o  (fb_state)
    );

    // Post-divider: stage 0 takes the upper field and feeds stage 1
    logic [N_STG:0]   stg_step;
    logic [PD_CW-1:0] stg_div [N_STG];

    assign stg_step[0] = in_run;

    for (genvar g = 0; g < N_STG; g++) begin : g_post
        localparam int LSB = (N_STG - 1 - g) * PD_W;

        assign stg_div[g] = PD_SPAN - {1'b0, post_cfg_i[LSB +: PD_W]};

        clksyn_post_stage #(
            .CW (PD_CW)
        ) i_stage (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (in_load),
            .step_i (stg_step[g]),
            .div_i  (stg_div[g]),
            .tick_o (stg_step[g+1])
        );
    end

    assign post_en_o = stg_step[N_STG];

endmodule

// File: rtl/clksyn_div_chain_chk.sv
`timescale 1ns/1ps
module clksyn_div_chain_chk #(
    parameter int RW = 6,
    parameter int FW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_load,
    input logic          ref_tick,
    input logic          ref_div,
    input logic [RW-1:0] ref_state,
    input logic [RW-1:0] ref_reload,
    input logic          fb_tick,
    input logic          fb_div,
    input logic [FW-1:0] fb_state,
    input logic [FW-1:0] fb_reload,
    input logic          post_en
);

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |-> (!ref_tick && !fb_tick && !post_en)); // R1

    AST_REF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (ref_div != $past(ref_div))); // R4

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(ref_div)); // R4

    AST_FB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> (fb_div != $past(fb_div))); // R4

    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_tick |=> $stable(fb_div)); // R4

    AST_REF_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (ref_state == $past(ref_reload))); // R6

    AST_FB_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> (fb_state == $past(fb_reload))); // R6

endmodule

bind clksyn_div_chain clksyn_div_chain_chk #(
    .RW (REF_W),
    .FW (FB_W)
) i_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .in_load    (in_load),
    .ref_tick   (ref_tick_o),
    .ref_div    (ref_div_o),
    .ref_state  (ref_state),
    .ref_reload (ref_reload_i),
    .fb_tick    (fb_tick_o),
    .fb_div     (fb_div_o),
    .fb_state   (fb_state),
    .fb_reload  (fb_reload_i),
    .post_en    (post_en_o)
);

// File: tb/test_clksyn_div_chain.sv
`timescale 1ns/1ps
module test_clksyn_div_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ref_rl = '0;
    logic [7:0] fb_rl = '0;
    logic [5:0] pcfg = '0;
    logic       ref_tick, ref_div, fb_tick, fb_div, post_en;

    always #2.5 clk = ~clk;   // 200 MHz

    clksyn_div_chain i_clksyn_div_chain (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ref_reload_i (ref_rl),
        .fb_reload_i  (fb_rl),
        .post_cfg_i   (pcfg),
        .ref_tick_o   (ref_tick),
        .ref_div_o    (ref_div),
        .fb_tick_o    (fb_tick),
        .fb_div_o     (fb_div),
        .post_en_o    (post_en)
    );

    int    cyc;
    int    q_ref[$];
    int    q_fb[$];
    int    q_post[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    int    lim = 0;
    int    seen_ref, seen_fb;
    string tag_ref = "R2", tag_fb = "R3", tag_post = "R5";

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Step the state sequence one place backwards
    function automatic int seq_prev(input int n, input int w, input int taps);
        int lowmask = (1 << (w - 1)) - 1;
        int plow    = n >> 1;
        int f       = n & 1;
        int z       = (plow == 0) ? 1 : 0;
        int oth     = $countones(plow & taps & lowmask) & 1;
        int msb     = f ^ oth ^ z;
        return (msb << (w - 1)) | plow;
    endfunction

    function automatic int reload_for(input int n, input int w, input int taps);
        int s = 1;
        for (int i = 1; i < n; i++) s = seq_prev(s, w, taps);
        return s;
    endfunction

    task automatic sched(ref int q[$], input int n1, input int c, input int n2, input int l);
        int t = n1;
        while (t <= l) begin
            q.push_back(t);
            t += (t >= c) ? n2 : n1;
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Scoreboard monitor: pops expected enable cycles and compares
    always @(negedge clk) begin
        int e;
        if (mon_on && rst_n && cyc <= lim) begin
            if (cyc == 0) begin
                chk(!ref_tick && !fb_tick && !post_en && !ref_div && !fb_div,
                    "R1", "outputs in load cycle",
                    {ref_tick, fb_tick, post_en, ref_div, fb_div}, 0);
                seen_ref = 0;
                seen_fb  = 0;
            end
            if (ref_tick) begin
                if (q_ref.size() == 0) chk(0, tag_ref, "unexpected ref tick cycle", cyc, -1);
                else begin
                    e = q_ref.pop_front();
                    chk(cyc == e, tag_ref, "ref tick cycle", cyc, e);
                end
                chk(ref_div == seen_ref[0], "R4", "ref level before flip", ref_div, seen_ref % 2);
                seen_ref++;
            end
            if (fb_tick) begin
                if (q_fb.size() == 0) chk(0, tag_fb, "unexpected fb tick cycle", cyc, -1);
                else begin
                    e = q_fb.pop_front();
                    chk(cyc == e, tag_fb, "fb tick cycle", cyc, e);
                end
                chk(fb_div == seen_fb[0], "R4", "fb level before flip", fb_div, seen_fb % 2);
                seen_fb++;
            end
            if (post_en) begin
                if (q_post.size() == 0) chk(0, tag_post, "unexpected post enable cycle", cyc, -1);
                else begin
                    e = q_post.pop_front();
                    chk(cyc == e, tag_post, "post enable cycle", cyc, e);
                end
            end
        end
    end

    // Driver: apply config under reset, check reset outputs, clear queues
    task automatic setup(input string tr, input string tf, input string tp,
                         input int rn, input int fn, input int d1, input int d2,
                         input int l);
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        mon_on   = 1'b0;
        tag_ref  = tr;
        tag_fb   = tf;
        tag_post = tp;
        ref_rl   = 6'(reload_for(rn, 6, 'h30));
        fb_rl    = 8'(reload_for(fn, 8, 'hB8));
        pcfg     = {3'(8 - d1), 3'(8 - d2)};
        lim      = l;
        q_ref.delete();
        q_fb.delete();
        q_post.delete();
        repeat (2) @(posedge clk);
        #1;
        chk(!ref_tick && !fb_tick && !post_en && !ref_div && !fb_div,
            "R1", "outputs during reset", {ref_tick, fb_tick, post_en, ref_div, fb_div}, 0);
    endtask

    task automatic release_rst();
        mon_on = 1'b1;
        rst_n  = 1'b1;
    endtask

    task automatic finish_case();
        wait_until(lim + 1);
        mon_on = 1'b0;
        chk(q_ref.size() == 0, tag_ref, "ref ticks missing", q_ref.size(), 0);
        chk(q_fb.size() == 0, tag_fb, "fb ticks missing", q_fb.size(), 0);
        chk(q_post.size() == 0, tag_post, "post enables missing", q_post.size(), 0);
    endtask

    initial begin
        // Case A: mid-range ratios (R2, R3, R4, R5)
        setup("R2", "R3", "R5", 5, 10, 2, 1, 200);
        sched(q_ref, 5, 1 << 30, 5, 200);
        sched(q_fb, 10, 1 << 30, 10, 200);
        sched(q_post, 2, 1 << 30, 2, 200);
        release_rst();
        finish_case();

        // Case B: smallest ratios, ref 1, fb 2, post 1x1
        setup("R2", "R3", "R5", 1, 2, 1, 1, 40);
        sched(q_ref, 1, 1 << 30, 1, 40);
        sched(q_fb, 2, 1 << 30, 2, 40);
        sched(q_post, 1, 1 << 30, 1, 40);
        release_rst();
        finish_case();

        // Case C: largest ratios, ref 64, fb 256, post 8x8
        setup("R2", "R3", "R5", 64, 256, 8, 8, 600);
        sched(q_ref, 64, 1 << 30, 64, 600);
        sched(q_fb, 256, 1 << 30, 256, 600);
        sched(q_post, 64, 1 << 30, 64, 600);
        release_rst();
        finish_case();

        // Case D: changes while running (R6 on dividers, R7 on post)
        setup("R6", "R6", "R7", 40, 5, 3, 2, 300);
        sched(q_ref, 40, 50, 3, 300);
        sched(q_fb, 5, 100, 7, 300);
        sched(q_post, 6, 12, 16, 300);
        release_rst();
        wait_until(12);
        pcfg = {3'(8 - 4), 3'(8 - 4)};
        wait_until(50);
        ref_rl = 6'(reload_for(3, 6, 'h30));
        wait_until(100);
        fb_rl = 8'(reload_for(7, 8, 'hB8));
        finish_case();

        // Case E: uneven post stages 5x3 with usable-range dividers
        setup("R2", "R3", "R5", 3, 256, 5, 3, 120);
        sched(q_ref, 3, 1 << 30, 3, 120);
        sched(q_fb, 256, 1 << 30, 256, 120);
        sched(q_post, 15, 1 << 30, 15, 120);
        release_rst();
        finish_case();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule